// File: doc/BRIEF.md
# Windowed Successive-Approximation Search Controller

This block is the synchronous digital half of a successive-approximation converter. It drives a 10-bit DAC control word, reads back one comparator decision per clock, and walks the word toward the input level. After a start strobe it holds the DAC at a start code for a fixed acquisition phase. It then runs one comparison per cycle. Each cycle moves the word up or down by a step taken from a per-cycle table. A final comparison settles the last code, and the block presents it as the result with a one-cycle done pulse.

The mode input picks one of four step sets. A full-range search starts from mid-scale and covers all 1024 codes. A window search starts from a supplied set-point and resolves only a narrow band around it, so it needs fewer cycles. Each of these can use a plain halving sequence or a redundant sequence whose steps shrink more slowly. The redundant sequence lets later cycles repair a wrong early decision, such as one caused by incomplete settling. The sum and the difference of the current word and the current step are both formed before every decision. The comparator bit therefore only chooses which of the two is registered.

Top module: `sar_window_ctl`

## Requirements
- R1: While reset is asserted, dac_o, result_o, sample_o and done_o are all zero.
- R2: A start_i seen high in idle makes sample_o high for exactly 3 cycles, beginning the next cycle. During those cycles dac_o holds 512 when mode_i[1]=0 (full range) or set_i when mode_i[1]=1 (window).
- R3: mode_i[0]=1 selects a redundant search and 0 a binary one. The number of comparison cycles is 10 for mode 0, 12 for mode 1, and 6 for modes 2 and 3. done_o rises in the cycle after the last comparison cycle, so the start edge and the done cycle are 3+K+1 edges apart.
- R4: In each comparison cycle before the last, a decision of 1 moves the word up by that cycle's step and a decision of 0 moves it down. The first steps are 256, 224, 16 and 7 for modes 0 to 3. Consecutive words in a conversion never differ by more than 256.
- R5: In full-range binary mode, with cmp_i = (input ≥ dac_o), the result equals the input code for every code 0 to 1023.
- R6: In full-range redundant mode (steps 224,128,72,40,24,12,6,4,2,1,1), the result equals the input code. This still holds when only the first decision is inverted, for input codes 512 to 578 and 445 to 511. In binary mode the same inverted first decision for input 560 ends at 511.
- R7: A window search clamps the input code to a band around the set-point. The band is set−19 to set+18 for redundant steps 7,5,3,2,1 and set−32 to set+31 for binary steps 16,8,4,2,1, each limited to 0..1023.
- R8: In window redundant mode, an inverted first decision still yields the exact code for inputs from set−5 to set+4.
- R9: The up and down words saturate at 1023 and 0 and never wrap.
- R10: start_i during a conversion is ignored. The conversion finishes at its normal time with the mode and set-point captured at its start, and no acquisition phase follows.
- R11: Mode and set-point are captured at each start, so back-to-back conversions may use different ones.
- R12: done_o is high for one cycle only. result_o changes only in a done cycle and holds its value until the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Conversion start strobe |
| mode_i | input | 2 | Bit 1: window search; bit 0: redundant steps |
| set_i | input | 10 | Window centre code |
| cmp_i | input | 1 | Comparator decision, 1 when input ≥ DAC level |
| dac_o | output | 10 | Current DAC control word |
| sample_o | output | 1 | High during the acquisition phase |
| done_o | output | 1 | One-cycle pulse with a new result |
| result_o | output | 10 | Last conversion result |

## Verification
The hardest case to reach is a wrong early comparator decision that the redundant steps must absorb. An ideal comparator never produces one. The bench's comparator model can invert only the first decision of a conversion, and the chosen inputs sit inside and just beside the tolerance band. The same inversion under binary steps shows the uncorrected outcome. A second hard case is a start strobe arriving mid-search. The bench raises it together with a changed mode and set-point partway through a conversion, then checks the latency, the result and the absence of a new acquisition phase.

// File: rtl/sar_pkg.sv
package sar_pkg;

    localparam int WORD_W      = 10;
    localparam int FULL_BIN_N  = WORD_W - 1;
    localparam int FULL_RED_N  = 11;
    localparam int WIN_N       = 5;
    localparam int MAX_STEPS   = FULL_RED_N;
    localparam int IDX_W       = $clog2(MAX_STEPS + 1);

    typedef logic [WORD_W-1:0] word_t;

    localparam word_t WORD_MAX    = '1;
    localparam word_t MID_CODE    = word_t'(1) << (WORD_W - 1);
    localparam word_t WIN_BIN_TOP = word_t'(16);

    // Redundant step sets: each step is at most one more than the sum of
    // the steps after it, so a bounded early mistake is recoverable.
    localparam word_t FULL_RED_TAB [FULL_RED_N] = '{
        10'd224, 10'd128, 10'd72, 10'd40, 10'd24, 10'd12,
        10'd6,   10'd4,   10'd2,  10'd1,  10'd1
    };
    localparam word_t WIN_RED_TAB [WIN_N] = '{10'd7, 10'd5, 10'd3, 10'd2, 10'd1};

    // bit 1: window search, bit 0: redundant steps
    typedef enum logic [1:0] {
        SRCH_FULL_BIN = 2'b00,
        SRCH_FULL_RED = 2'b01,
        SRCH_WIN_BIN  = 2'b10,
        SRCH_WIN_RED  = 2'b11
    } srch_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SAMP = 2'd1,
        ST_CONV = 2'd2
    } st_e;

endpackage

// File: rtl/sar_step_rom.sv
module sar_step_rom
    import sar_pkg::*;
(
    input  srch_e             mode_i,
    input  logic [IDX_W-1:0]  idx_i,
    output word_t             step_o,
    output logic              last_o
);

    word_t            bin_full [FULL_BIN_N];
    logic [IDX_W-1:0] n_steps;

    generate
        for (genvar i = 0; i < FULL_BIN_N; i++) begin : g_bin
            assign bin_full[i] = word_t'(1) << (WORD_W - 2 - i);
        end
    endgenerate

    always_comb begin
        unique case (mode_i)
            SRCH_FULL_BIN: n_steps = IDX_W'(FULL_BIN_N);
            SRCH_FULL_RED: n_steps = IDX_W'(FULL_RED_N);
            default:       n_steps = IDX_W'(WIN_N);
        endcase
        last_o = (idx_i == n_steps);
        // The closing comparison uses a unit step: keep the word or drop one.
        step_o = word_t'(1);
        if (!last_o) begin
            unique case (mode_i)
                SRCH_FULL_BIN: step_o = bin_full[idx_i];
                SRCH_FULL_RED: step_o = FULL_RED_TAB[idx_i];
                SRCH_WIN_BIN:  step_o = WIN_BIN_TOP >> idx_i;
                SRCH_WIN_RED:  step_o = WIN_RED_TAB[idx_i];
            endcase
        end
    end

endmodule

// File: rtl/sar_cand.sv
module sar_cand
    import sar_pkg::*;
(
    input  word_t word_i,
    input  word_t step_i,
    output word_t up_o,
    output word_t dn_o
);

    logic [WORD_W:0] sum;
    logic [WORD_W:0] diff;

    assign sum  = {1'b0, word_i} + {1'b0, step_i};
    assign diff = {1'b0, word_i} - {1'b0, step_i};

    assign up_o = sum[WORD_W]  ? WORD_MAX : sum[WORD_W-1:0];
    assign dn_o = diff[WORD_W] ? '0       : diff[WORD_W-1:0];

endmodule

// File: rtl/sar_window_ctl.sv
module sar_window_ctl
    import sar_pkg::*;
#(
    parameter int ACQ_CYC = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [1:0]        mode_i,
    input  logic [WORD_W-1:0] set_i,
    input  logic              cmp_i,
    output logic [WORD_W-1:0] dac_o,
    output logic              sample_o,
    output logic              done_o,
    output logic [WORD_W-1:0] result_o
);

    localparam int ACQ_W = $clog2(ACQ_CYC + 1);
    localparam int CNT_W = (ACQ_W > IDX_W) ? ACQ_W : IDX_W;

    typedef struct packed {
        st_e              st;
        srch_e            mode;
        word_t            word;
        logic [CNT_W-1:0] cnt;
        word_t            result;
        logic             done;
    } ctl_s;

    ctl_s  d, q;
    word_t step;
    word_t up_word;
    word_t dn_word;
    logic  last;
    logic  busy;

    sar_step_rom i_rom (
        .mode_i (q.mode),
        .idx_i  (q.cnt[IDX_W-1:0]),
        .step_o (step),
        .last_o (last)
    );

    sar_cand i_cand (
        .word_i (q.word),
        .step_i (step),
        .up_o   (up_word),
        .dn_o   (dn_word)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.st   = ST_SAMP;
                    d.mode = srch_e'(mode_i);
                    d.word = mode_i[1] ? set_i : MID_CODE;
                    d.cnt  = '0;
                end
            end
            ST_SAMP: begin
                if (q.cnt == CNT_W'(ACQ_CYC - 1)) begin
                    d.st  = ST_CONV;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_CONV: begin
                if (last) begin
                    d.st     = ST_IDLE;
                    d.done   = 1'b1;
                    d.result = cmp_i ? q.word : dn_word;
                end else begin
                    d.word = cmp_i ? up_word : dn_word;
                    d.cnt  = q.cnt + 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q.st     <= ST_IDLE;
            q.mode   <= SRCH_FULL_BIN;
            q.word   <= '0;
            q.cnt    <= '0;
            q.result <= '0;
            q.done   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign busy     = (q.st != ST_IDLE);
    assign dac_o    = q.word;
    assign sample_o = (q.st == ST_SAMP);
    assign done_o   = q.done;
    assign result_o = q.result;

endmodule

// File: rtl/sar_window_ctl_chk.sv
module sar_window_ctl_chk
    import sar_pkg::*;
#(
    parameter int ACQ_CYC = 3
) (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        start_i,
    input logic        busy,
    input logic        sample_o,
    input logic        done_o,
    input word_t       dac_o,
    input word_t       result_o
);

    localparam int RUN_W = $clog2(ACQ_CYC + 1) + 1;

    logic [RUN_W-1:0] run_q;
    logic             conv;

    assign conv = busy && !sample_o;

    always_ff @(posedge clk_i) begin
        if (!rst_ni)       run_q <= '0;
        else if (sample_o) run_q <= run_q + 1'b1;
        else               run_q <= '0;
    end

    a_r2_start_samples: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy && start_i) |=> sample_o);

    a_r2_acq_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(sample_o) |-> (run_q == RUN_W'(ACQ_CYC)));

    a_r2_dac_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sample_o && $past(sample_o)) |-> $stable(dac_o));

    a_r3_done_after_conv: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (!busy && $past(conv)));

    a_r4_step_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (conv && $past(conv)) |->
        ((dac_o >= $past(dac_o)) ? ((dac_o - $past(dac_o)) <= (MID_CODE >> 1))
                                 : (($past(dac_o) - dac_o) <= (MID_CODE >> 1))));

    a_r10_busy_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (conv && start_i) |=> !sample_o);

    a_r12_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    a_r12_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |-> $stable(result_o));

endmodule

bind sar_window_ctl sar_window_ctl_chk #(.ACQ_CYC(ACQ_CYC)) i_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .busy     (busy),
    .sample_o (sample_o),
    .done_o   (done_o),
    .dac_o    (dac_o),
    .result_o (result_o)
);

// File: tb/test_sar_window_ctl.sv
module test_sar_window_ctl;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       start_i;
    logic [1:0] mode_i;
    logic [9:0] set_i;
    logic       cmp_i;
    logic [9:0] dac_o;
    logic       sample_o;
    logic       done_o;
    logic [9:0] result_o;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  ended  = 0;

    always #10 clk = ~clk;

    sar_window_ctl i_sar_window_ctl (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .start_i  (start_i),
        .mode_i   (mode_i),
        .set_i    (set_i),
        .cmp_i    (cmp_i),
        .dac_o    (dac_o),
        .sample_o (sample_o),
        .done_o   (done_o),
        .result_o (result_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int n_cmp(input int m);
        if (m == 0) return 10;
        if (m == 1) return 12;
        return 6;
    endfunction

    function automatic int exp_res(input int m, input int sp, input int x);
        int up, lo, hi;
        if (m < 2) return x;
        up = (m == 3) ? 18 : 31;
        lo = (sp - up - 1 < 0) ? 0 : sp - up - 1;
        hi = (sp + up > 1023) ? 1023 : sp + up;
        if (x < lo) return lo;
        if (x > hi) return hi;
        return x;
    endfunction

    // One conversion with a comparator model; optional inverted first decision
    // and optional start pulse with changed mode/set-point mid-search.
    task automatic run(input int m, input int sp, input int x, input bit flip,
                       input bit poke, output int res, output int lat,
                       output int k, output int samp, output int dac0,
                       output int first, output int mn, output int mx);
        @(negedge clk);
        mode_i  = 2'(m);
        set_i   = 10'(sp);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat = 1; k = 0; samp = 0; first = -1; mn = 1023; mx = 0;
        dac0 = int'(dac_o);
        while (!done_o && lat < 200) begin
            if (sample_o) begin
                samp++;
            end else begin
                if (k == 1) first = int'(dac_o);
                if (int'(dac_o) < mn) mn = int'(dac_o);
                if (int'(dac_o) > mx) mx = int'(dac_o);
                cmp_i = (x >= int'(dac_o)) ^ (flip && k == 0);
                if (poke && k == 2) begin
                    start_i = 1'b1;
                    mode_i  = ~2'(m);
                    set_i   = 10'(sp) ^ 10'h155;
                end else begin
                    start_i = 1'b0;
                end
                k++;
            end
            @(negedge clk);
            lat++;
        end
        start_i = 1'b0;
        res = int'(result_o);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            n_chk++;
            n_fail++;
            $display("FAIL R3 watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int res, lat, k, samp, dac0, first, mn, mx, sp, x, m, e;
        void'($urandom(32'd2024));
        rst_n = 1'b0; start_i = 1'b0; mode_i = 2'd0; set_i = 10'd0; cmp_i = 1'b0;
        repeat (3) @(negedge clk);
        chk(dac_o == 0,    "R1", "reset dac",    int'(dac_o), 0);
        chk(result_o == 0, "R1", "reset result", int'(result_o), 0);
        chk(!sample_o,     "R1", "reset sample", int'(sample_o), 0);
        chk(!done_o,       "R1", "reset done",   int'(done_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!sample_o, "R2", "no sampling without start", int'(sample_o), 0);

        // full binary, top and bottom codes
        run(0, 0, 1023, 0, 0, res, lat, k, samp, dac0, first, mn, mx);
        chk(res == 1023, "R5", "full bin x=1023", res, 1023);
        chk(lat == 14,   "R3", "full bin latency", lat, 14);
        chk(k == 10,     "R3", "full bin comparisons", k, 10);
        chk(samp == 3,   "R2", "acq cycles", samp, 3);
        chk(dac0 == 512, "R2", "full start code", dac0, 512);
        chk(first == 768, "R4", "full bin first step up", first, 768);
        repeat (3) begin
            @(negedge clk);
            chk(!done_o, "R12", "done single cycle", int'(done_o), 0);
            chk(result_o == 1023, "R12", "result holds", int'(result_o), 1023);
        end
        run(0, 0, 0, 0, 0, res, lat, k, samp, dac0, first, mn, mx);
        chk(res == 0,     "R5", "full bin x=0", res, 0);
        chk(first == 256, "R4", "full bin first step down", first, 256);

        // full redundant
        run(1, 0, 300, 0, 0, res, lat, k, samp, dac0, first, mn, mx);
        chk(res == 300,   "R6", "full red x=300", res, 300);
        chk(k == 12,      "R3", "full red comparisons", k, 12);
        chk(first == 288, "R4", "full red first step", first, 288);
        run(1, 0, 560, 1, 0, res, lat, k, samp, dac0, first, mn, mx);
        chk(res == 560, "R6", "full red wrong first x=560", res, 560);
        run(1, 0, 470, 1, 0, res, lat, k, samp, dac0, first, mn, mx);
        chk(res == 470, "R6", "full red wrong first x=470", res, 470);
        run(1, 0, 1023, 0, 0, res, lat, k, samp, dac0, first, mn, mx);
        chk(res == 1023, "R9", "full red top saturates", res, 1023);
        run(0, 0, 560, 1, 0, res, lat, k, samp, dac0, first, mn, mx);
        chk(res == 511, "R6", "full bin wrong first not repaired", res, 511);

        // window redundant
        run(3, 600, 610, 0, 0, res, lat, k, samp, dac0, first, mn, mx);
        chk(res == 610,   "R7", "win red inside", res, 610);
        chk(dac0 == 600,  "R2", "win start code", dac0, 600);
        chk(k == 6,       "R3", "win red comparisons", k, 6);
        chk(first == 607, "R4", "win red first step", first, 607);
        run(3, 600, 700, 0, 0, res, lat, k, samp, dac0, first, mn, mx);
        chk(res == 618, "R7", "win red above band", res, 618);
        run(3, 600, 0, 0, 0, res, lat, k, samp, dac0, first, mn, mx);
        chk(res == 581, "R7", "win red below band", res, 581);

        // window binary
        run(2, 300, 340, 0, 0, res, lat, k, samp, dac0, first, mn, mx);
        chk(res == 331, "R7", "win bin above band", res, 331);
        run(2, 300, 270, 0, 0, res, lat, k, samp, dac0, first, mn, mx);
        chk(res == 270,   "R7", "win bin inside", res, 270);
        chk(first == 284, "R4", "win bin first step", first, 284);
        chk(lat == 10,    "R3", "win bin latency", lat, 10);

        // window redundancy
        run(3, 400, 404, 1, 0, res, lat, k, samp, dac0, first, mn, mx);
        chk(res == 404, "R8", "win red wrong first x=set+4", res, 404);
        run(3, 400, 395, 1, 0, res, lat, k, samp, dac0, first, mn, mx);
        chk(res == 395, "R8", "win red wrong first x=set-5", res, 395);

        // saturation
        run(3, 1020, 1023, 0, 0, res, lat, k, samp, dac0, first, mn, mx);
        chk(res == 1023, "R9", "top clamp result", res, 1023);
        chk(mn >= 1000,  "R9", "no wrap at top", mn, 1000);
        run(3, 3, 0, 0, 0, res, lat, k, samp, dac0, first, mn, mx);
        chk(res == 0,  "R9", "bottom clamp result", res, 0);
        chk(mx <= 40,  "R9", "no wrap at bottom", mx, 40);

        // start while busy
        run(0, 0, 777, 0, 1, res, lat, k, samp, dac0, first, mn, mx);
        chk(res == 777, "R10", "busy start ignored result", res, 777);
        chk(lat == 14,  "R10", "busy start ignored latency", lat, 14);
        @(negedge clk);
        chk(!sample_o, "R10", "no acquisition after busy start", int'(sample_o), 0);

        // back-to-back different settings
        run(2, 100, 90, 0, 0, res, lat, k, samp, dac0, first, mn, mx);
        chk(res == 90, "R11", "first of pair", res, 90);
        run(1, 900, 900, 0, 0, res, lat, k, samp, dac0, first, mn, mx);
        chk(res == 900 && dac0 == 512, "R11", "second of pair", res, 900);

        // random mix
        for (int i = 0; i < 150; i++) begin
            m  = int'($urandom % 4);
            sp = int'($urandom % 1024);
            if (m >= 2) begin
                x = sp + int'($urandom % 91) - 45;
                if (x < 0) x = 0;
                if (x > 1023) x = 1023;
            end else begin
                x = int'($urandom % 1024);
            end
            run(m, sp, x, 0, 0, res, lat, k, samp, dac0, first, mn, mx);
            e = exp_res(m, sp, x);
            chk(res == e, (m >= 2) ? "R7" : "R5", "random result", res, e);
            chk(lat == n_cmp(m) + 4, "R3", "random latency", lat, n_cmp(m) + 4);
        end

        if (!ended) begin
            ended = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule